// File: doc/BRIEF.md
# Dual Reloading Interval Timer

Two identical 32-bit down-counters sit behind a word-wide register port. Each counter has a reload value (divisor), a control word and a count that can be read back. The control word picks a tick source and an operation. Load copies the divisor into the count. Hold freezes the count. Run makes the counter step down once per selected tick and reload itself automatically. Each time a running counter wraps, it raises its own bit in a shared interrupt status.

A common interrupt stage holds the raw status, an enable mask, and an acknowledge port that clears bits without storing anything. It drives a single level-sensitive interrupt line that is high while any enabled status bit is set. A free-running time counter steps once per pulse on a dedicated 100 MHz tick-enable and can be read. Clock generation is outside the block: every tick source arrives as a single-cycle enable in the `clk` domain.

Top module: `dtmr_dual_top`

## Requirements
- R1: After reset both counts read 0, the raw status, mask and masked status read 0, the time counter reads 0, `irq` is low, and neither counter advances until a run operation is written.
- R2: A control write with bits [1:0] = 0 (load) copies that timer's stored divisor into its count on the same clock edge. The counter then stays stopped.
- R3: A control write with bits [1:0] = 1 (hold) stops the counter, and its count stays unchanged on later ticks.
- R4: With bits [1:0] = 2 (run), each selected tick lowers the count by one. A tick that arrives while the count is 0 or 1 loads the divisor instead and marks an expiry, so the interval is divisor ticks long.
- R5: Control bits [4:2] choose the tick source. Codes 4, 5, 6 and 7 select `tick_src[0]`, `[1]`, `[2]` and `[3]`. Any other code selects no source, and a running counter with such a code never changes.
- R6: Writing a divisor register (timer0 at 0x00, timer1 at 0x10) only stores the value. The count does not change until a later load or run.
- R7: An expiry of timer0 sets raw status bit 0, and an expiry of timer1 sets bit 1. Raw status reads at 0x50.
- R8: Writing 0x4C clears every raw bit whose written bit is 1 and leaves the other bits alone. An expiry in the same cycle as its own clear wins. 0x4C reads as 0.
- R9: The mask is at 0x48 (bits [1:0]). Masked status at 0x54 equals raw AND mask, and `irq` is high exactly when the masked status is nonzero.
- R10: The time counter at 0x38 increases by one on every cycle in which `time_tick` is high.
- R11: Counts read at 0x04 and 0x14. Divisor, control and unmapped addresses read 0. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| tick_src | input | 4 | Tick enables for source codes 4..7 |
| time_tick | input | 1 | 100 MHz tick enable for the time counter |
| irq | output | 1 | Level interrupt, any masked status bit |

## Verification
The assertions assume that every tick input is a clean single-cycle enable, synchronous to `clk`. They also assume that the register port makes at most one access per cycle, so a control write and a tick cannot both claim a counter unless the control write is given priority. The bench drives ticks and bus accesses only on falling edges and holds each one for exactly one cycle. The one place it overlaps them on purpose is the acknowledge/expiry race, where the priority rule is what is being checked.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 8;
  localparam int NTMR   = 2;
  localparam int NSRC   = 4;
  localparam int STRIDE = 16;

  localparam logic [ADDR_W-1:0] A_DIV   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT   = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h08;
  localparam logic [ADDR_W-1:0] A_TIME  = 8'h38;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h48;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_RAW   = 8'h50;
  localparam logic [ADDR_W-1:0] A_MSKD  = 8'h54;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  function automatic logic at_wrap(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] d);
    return at_wrap(c) ? d : c - CNT_W'(1);
  endfunction

  function automatic logic pick_tick(input logic [2:0] code,
                                     input logic [NSRC-1:0] ticks);
    return code[2] ? ticks[code[1:0]] : 1'b0;
  endfunction
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [NSRC-1:0]  tick_src,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] div_q, cnt_q;
  op_e              op_q;
  logic [2:0]       src_q;
  logic             running, tick_sel, adv;

  assign running  = (op_q == OP_RUN);
  assign tick_sel = pick_tick(src_q, tick_src);
  assign adv      = running && tick_sel && !ctrl_we;
  assign expire   = adv && at_wrap(cnt_q);
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      op_q  <= OP_HOLD;
      src_q <= '0;
    end else begin
      if (div_we) div_q <= wdata;
      if (ctrl_we) begin
        op_q  <= op_e'(wdata[1:0]);
        src_q <= wdata[4:2];
        if (op_e'(wdata[1:0]) == OP_LOAD) cnt_q <= div_q;
      end else if (adv) begin
        cnt_q <= next_count(cnt_q, div_q);
      end
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctrl_we) |=> $stable(count));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(div_q)));
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[1:0] == 2'd0) |=> (count == $past(div_q)));
  // R5
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_q[2] && !ctrl_we) |=> $stable(count));
endmodule

// File: rtl/dtmr_irq_unit.sv
module dtmr_irq_unit
  import dtmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTMR-1:0] expire,
  input  logic            mask_we,
  input  logic            ack_we,
  input  logic [NTMR-1:0] wbits,
  output logic [NTMR-1:0] raw,
  output logic [NTMR-1:0] mask,
  output logic            irq
);
  logic [NTMR-1:0] raw_q, mask_q, clr;

  assign clr  = ack_we ? wbits : '0;
  assign raw  = raw_q;
  assign mask = mask_q;
  assign irq  = |(raw_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | expire;
      if (mask_we) mask_q <= wbits;
    end
  end

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_chk
      // R7
      raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire[i] |=> raw[i]);
      // R8
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !expire[i]) |=> !raw[i]);
    end
  endgenerate

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && wbits == '0) |=> !irq);
endmodule

// File: rtl/dtmr_dual_top.sv
module dtmr_dual_top
  import dtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              time_tick,
  output logic              irq
);
  logic                  wr;
  logic [CNT_W-1:0]      cnt   [NTMR];
  logic [NTMR-1:0]       expire;
  logic [NTMR-1:0]       raw, mask;
  logic [CNT_W-1:0]      time_q;

  assign wr = bus_sel && bus_wr;

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * STRIDE);
      dtmr_channel u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_we   (wr && bus_addr == (BASE | A_DIV)),
        .ctrl_we  (wr && bus_addr == (BASE | A_CTRL)),
        .wdata    (bus_wdata),
        .tick_src (tick_src),
        .count    (cnt[i]),
        .expire   (expire[i])
      );
    end
  endgenerate

  dtmr_irq_unit u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mask_we (wr && bus_addr == A_MASK),
    .ack_we  (wr && bus_addr == A_ACK),
    .wbits   (bus_wdata[NTMR-1:0]),
    .raw     (raw),
    .mask    (mask),
    .irq     (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         time_q <= '0;
    else if (time_tick) time_q <= time_q + CNT_W'(1);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        A_CNT:            bus_rdata = cnt[0];
        A_CNT | 8'h10:    bus_rdata = cnt[1];
        A_TIME:           bus_rdata = time_q;
        A_MASK:           bus_rdata = CNT_W'(mask);
        A_RAW:            bus_rdata = CNT_W'(raw);
        A_MSKD:           bus_rdata = CNT_W'(raw & mask);
        default:          bus_rdata = '0;
      endcase
    end
  end

  // R10
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_tick |=> (time_q == $past(time_q) + CNT_W'(1)));
endmodule

// File: tb/dtmr_dual_top_tb.sv
module dtmr_dual_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = 0;
  logic        time_tick = 0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dtmr_dual_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic tick(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_src = 4'(1 << src);
      @(negedge clk); tick_src = 0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h04, v); chk("R1 cnt0", v, 0);
    rd(8'h14, v); chk("R1 cnt1", v, 0);
    rd(8'h50, v); chk("R1 raw", v, 0);
    rd(8'h48, v); chk("R1 mask", v, 0);
    rd(8'h38, v); chk("R1 time", v, 0);
    chk("R1 irq", irq, 0);
    tick(0, 1); rd(8'h04, v); chk("R1 stopped", v, 0);
  endtask

  task automatic t_load_run;
    logic [31:0] v;
    wr(8'h00, 5); rd(8'h04, v); chk("R6 div only stores", v, 0);
    wr(8'h08, 32'h10); rd(8'h04, v); chk("R2 load", v, 5);
    tick(0, 1); rd(8'h04, v); chk("R2 stays stopped", v, 5);
    wr(8'h08, 32'h12);
    tick(0, 4); rd(8'h04, v); chk("R4 decrement", v, 1);
    rd(8'h50, v); chk("R4 no early expiry", v, 0);
    tick(1, 2); rd(8'h04, v); chk("R5 wrong source", v, 1);
    tick(0, 1); rd(8'h04, v); chk("R4 reload", v, 5);
    rd(8'h50, v); chk("R7 raw bit0", v, 1);
    chk("R9 masked off irq", irq, 0);
  endtask

  task automatic t_mask_ack;
    logic [31:0] v;
    wr(8'h48, 1); chk("R9 irq on", irq, 1);
    rd(8'h54, v); chk("R9 masked", v, 1);
    wr(8'h48, 2); chk("R9 irq other mask", irq, 0);
    rd(8'h54, v); chk("R9 masked other", v, 0);
    wr(8'h4C, 2); rd(8'h50, v); chk("R8 ack other bit", v, 1);
    wr(8'h4C, 1); rd(8'h50, v); chk("R8 ack clears", v, 0);
    rd(8'h4C, v); chk("R8 ack reads 0", v, 0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    tick(0, 1); rd(8'h04, v); chk("R4 running", v, 4);
    wr(8'h08, 32'h11);
    tick(0, 3); rd(8'h04, v); chk("R3 hold", v, 4);
  endtask

  task automatic t_race;
    logic [31:0] v;
    wr(8'h10, 2); wr(8'h18, 32'h1E);
    tick(3, 1); rd(8'h14, v); chk("R4 wrap from zero", v, 2);
    rd(8'h50, v); chk("R7 raw bit1", v, 2);
    wr(8'h4C, 2); tick(3, 1);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 8'h4C; bus_wdata = 2; tick_src = 4'h8;
    @(negedge clk); bus_sel = 0; bus_wr = 0; tick_src = 0;
    rd(8'h50, v); chk("R8 expiry wins", v, 2);
    rd(8'h14, v); chk("R4 timer1 reload", v, 2);
    wr(8'h4C, 3); rd(8'h50, v); chk("R8 clear after race", v, 0);
  endtask

  task automatic t_nosrc;
    logic [31:0] v;
    wr(8'h18, 32'h02);
    for (int s = 0; s < 4; s++) tick(s, 1);
    rd(8'h14, v); chk("R5 disabled code", v, 2);
    wr(8'h18, 32'h16); tick(1, 1);
    rd(8'h14, v); chk("R5 code5 src1", v, 1);
  endtask

  task automatic t_time;
    logic [31:0] v;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); time_tick = 1;
      @(negedge clk); time_tick = 0;
    end
    rd(8'h38, v); chk("R10 time", v, 7);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h48, 3);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R11 unmapped read", v, 0);
    rd(8'h48, v); chk("R11 mask untouched", v, 3);
    rd(8'h04, v); chk("R11 count kept", v, 4);
    rd(8'h00, v); chk("R11 div reads 0", v, 0);
    rd(8'h08, v); chk("R11 ctrl reads 0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_load_run; t_mask_ack; t_hold; t_race; t_nosrc; t_time; t_unmapped;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule